// File: doc/BRIEF.md
# Strobe/Sense Key Matrix Emulator with Paced Scancode Queue

This block stands in for a physical keyboard behind a strobe/sense scan interface. A host scanner drives a vector of column strobes and reads back one sense bit per row. The block holds the row masks of the keys that are held down. Every clock it registers, for each row, whether any held key in that row lies on an active strobe.

Key events enter as 8-bit scancodes through a single-cycle push port. They wait in a 16-entry circular queue, and a clock divider releases one of them per tick, which is a slow, fixed rate. Each released code is looked up in a synchronous ROM. The ROM returns a packed row/column position, a side-band switch number, or an invalid marker. The matrix or the switch outputs are then updated. One switch line leaves the block inverted.

Top module: `kbm_matrix_emu`

## Requirements
- R1: While reset is held and right after it, sense_o is all zero, overflow_o is 0 and side_o equals 5'b10000: all internal switch states are low and the fifth line is inverted.
- R2: sense_o[r] in a cycle equals 1 exactly when, in the previous cycle, row r held a pressed key whose column strobe was high. A strobe change therefore shows on sense_o one cycle later.
- R3: A scancode with bit 7 clear and index (bits 6:0) in 1..77 presses the key at row (index-1)/11, column (index-1)%11.
- R4: The same index with bit 7 set releases that key and clears its mask bit.
- R5: Indices 0, 78..95 and 101..127 map to the invalid entry 8'hFF. Whether pressed or released, they leave sense_o and side_o unchanged.
- R6: Index 96+k (k = 0..4) is routed to switch k and not to the matrix. Press drives the switch state high and release drives it low. side_o[k] carries that state, except side_o[4], which carries its inverse.
- R7: Queued scancodes are applied in arrival order. The queue holds at most 16 of them.
- R8: A tick occurs every TICK_DIV clocks, the first on the TICK_DIV-th clock after reset. Each tick applies at most one queued code. A side_o change appears 2 clocks after the tick edge, and the resulting sense_o change appears 3 clocks after it.
- R9: A push that arrives while 16 codes are queued is discarded. It sets overflow_o, which then stays at 1 until reset.
- R10: Switch codes leave every row mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_valid_i | input | 1 | Pushes code_i into the queue this cycle |
| code_i | input | 8 | Scancode: bit 7 is release, bits 6:0 are the lookup index |
| strobe_i | input | 11 | Column strobes from the host scanner |
| sense_o | output | 7 | Registered row sense bits |
| side_o | output | 5 | Side-band switch outputs; bit 4 is inverted |
| overflow_o | output | 1 | Sticky flag for a dropped push |

## Verification
The assertions take for granted several things about the inputs. rst_n is low for at least one clock edge. Strobe and push inputs are stable around the rising edge. TICK_DIV is at least 2, so ticks never fall on adjacent cycles. The bench drives every input just after a falling edge. It overrides TICK_DIV with a small value so that ticks fall inside a short run. It reaches a full queue through bursts of consecutive pushes between ticks. The bench holds a behavioural model of the queue, the tick counter and the row masks, and compares all outputs with it every cycle while strobe patterns walk across the columns.

// File: rtl/kbm_pkg.sv
package kbm_pkg;
   localparam int CODE_W    = 8;
   localparam int IDX_W     = 7;
   localparam int MAP_N     = 1 << IDX_W;
   localparam int POS_W     = 4;
   localparam int SIDE_BASE = 96;
   localparam logic [CODE_W-1:0] MAP_NONE = 8'hFF;

   typedef logic [MAP_N-1:0][CODE_W-1:0] keymap_t;

   // Dense matrix keys from index 1, switches from SIDE_BASE, rest invalid.
   function automatic keymap_t build_keymap(int rows, int cols, int sides);
      keymap_t m;
      int r;
      int c;
      for (int i = 0; i < MAP_N; i++) begin
         m[i] = MAP_NONE;
         if (i >= 1 && i <= rows * cols) begin
            r = (i - 1) / cols;
            c = (i - 1) % cols;
            m[i] = {r[POS_W-1:0], c[POS_W-1:0]};
         end
         if (i >= SIDE_BASE && i < SIDE_BASE + sides) begin
            r = rows;
            c = i - SIDE_BASE;
            m[i] = {r[POS_W-1:0], c[POS_W-1:0]};
         end
      end
      return m;
   endfunction
endpackage

// File: rtl/kbm_pacer.sv
module kbm_pacer #(
   parameter int TICK_DIV = 6250000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

   if (TICK_DIV < 2) begin : g_bad_div
      $error("kbm_pacer: TICK_DIV must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   assign tick_o = (cnt_q == CNT_W'(TICK_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end

   AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o); // R8
endmodule

// File: rtl/kbm_queue.sv
module kbm_queue #(
   parameter int DEPTH = 16,
   parameter int W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic [W-1:0] data_i,
   input  logic         pop_i,
   output logic [W-1:0] head_o,
   output logic         popped_o,
   output logic         ovf_o
);
   localparam int  PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int  CNT_W = $clog2(DEPTH + 1);
   localparam bit  POW2  = (DEPTH & (DEPTH - 1)) == 0;

   if (DEPTH < 2) begin : g_bad_depth
      $error("kbm_queue: DEPTH must be at least 2");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] rd_ptr, wr_ptr, rd_nxt, wr_nxt;
   logic [CNT_W-1:0] count;
   logic             full, empty, accept, take;

   assign full     = (count == CNT_W'(DEPTH));
   assign empty    = (count == '0);
   assign accept   = push_i && !full;
   assign take     = pop_i && !empty;
   assign head_o   = mem[rd_ptr];
   assign popped_o = take;

   if (POW2) begin : g_wrap_free
      assign rd_nxt = rd_ptr + 1'b1;
      assign wr_nxt = wr_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (accept) mem[wr_ptr] <= data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
         ovf_o  <= 1'b0;
      end else begin
         if (accept) wr_ptr <= wr_nxt;
         if (take)   rd_ptr <= rd_nxt;
         case ({accept, take})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
         if (push_i && full) ovf_o <= 1'b1;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && full) |=> ovf_o); // R9
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> ovf_o); // R9
   AST_DRAIN_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !pop_i |=> (count >= $past(count))); // R8
   AST_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      full |=> (count == $past(count)) || (count == $past(count) - 1'b1)); // R7
endmodule

// File: rtl/kbm_keymap_rom.sv
module kbm_keymap_rom
   import kbm_pkg::*;
#(
   parameter keymap_t TABLE = '1
) (
   input  logic              clk,
   input  logic              rd_en_i,
   input  logic [IDX_W-1:0]  addr_i,
   output logic [CODE_W-1:0] data_o
);
   always_ff @(posedge clk) begin
      if (rd_en_i) data_o <= TABLE[addr_i];
   end
endmodule

// File: rtl/kbm_matrix.sv
module kbm_matrix
   import kbm_pkg::*;
#(
   parameter int NUM_SENSE  = 7,
   parameter int NUM_STROBE = 11,
   parameter int NUM_SIDE   = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   apply_i,
   input  logic [CODE_W-1:0]      map_i,
   input  logic                   release_i,
   input  logic [NUM_STROBE-1:0]  strobe_i,
   output logic [NUM_SENSE-1:0]   sense_o,
   output logic [NUM_SIDE-1:0]    side_o
);
   localparam int MASK_W = 1 << POS_W;

   if (NUM_STROBE > MASK_W) begin : g_bad_cols
      $error("kbm_matrix: NUM_STROBE exceeds column field");
   end
   if (NUM_SENSE > MASK_W - 1) begin : g_bad_rows
      $error("kbm_matrix: NUM_SENSE leaves no row for switches");
   end
   if (NUM_SIDE > MASK_W) begin : g_bad_side
      $error("kbm_matrix: NUM_SIDE exceeds column field");
   end

   logic [NUM_SENSE-1:0][MASK_W-1:0] mask;
   logic [POS_W-1:0] map_row, map_col;
   logic             entry_ok, key_hit, side_hit;
   logic [MASK_W-1:0] strobe_ext;

   assign map_row    = map_i[CODE_W-1:POS_W];
   assign map_col    = map_i[POS_W-1:0];
   assign entry_ok   = (map_i != MAP_NONE);
   assign key_hit    = apply_i && entry_ok && ({1'b0, map_row} < (POS_W+1)'(NUM_SENSE));
   assign side_hit   = apply_i && entry_ok && (map_row == POS_W'(NUM_SENSE)) &&
                       ({1'b0, map_col} < (POS_W+1)'(NUM_SIDE));
   assign strobe_ext = MASK_W'(strobe_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask    <= '0;
         sense_o <= '0;
         side_o  <= '0;
      end else begin
         for (int r = 0; r < NUM_SENSE; r++) begin
            sense_o[r] <= |(mask[r] & strobe_ext);
            if (key_hit && map_row == POS_W'(r)) mask[r][map_col] <= !release_i;
         end
         for (int k = 0; k < NUM_SIDE; k++) begin
            if (side_hit && map_col == POS_W'(k)) side_o[k] <= !release_i;
         end
      end
   end

   AST_IDLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_i == '0) |=> (sense_o == '0)); // R2
   AST_SIDE_OFF_MATRIX: assert property (@(posedge clk) disable iff (!rst_n)
      side_hit |=> $stable(mask)); // R10
   AST_INVALID_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (apply_i && !entry_ok) |=> ($stable(mask) && $stable(side_o))); // R5
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !apply_i |=> ($stable(mask) && $stable(side_o))); // R8
endmodule

// File: rtl/kbm_matrix_emu.sv
module kbm_matrix_emu
   import kbm_pkg::*;
#(
   parameter int      NUM_SENSE   = 7,
   parameter int      NUM_STROBE  = 11,
   parameter int      NUM_SIDE    = 5,
   parameter int      QDEPTH      = 16,
   parameter int      TICK_DIV    = 6250000,
   parameter logic [NUM_SIDE-1:0] SIDE_INVERT = 5'b10000,
   parameter keymap_t KEYMAP      = build_keymap(NUM_SENSE, NUM_STROBE, NUM_SIDE)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  code_valid_i,
   input  logic [CODE_W-1:0]     code_i,
   input  logic [NUM_STROBE-1:0] strobe_i,
   output logic [NUM_SENSE-1:0]  sense_o,
   output logic [NUM_SIDE-1:0]   side_o,
   output logic                  overflow_o
);
   logic              tick, popped;
   logic [CODE_W-1:0] head, map_q;
   logic              s1_vld, s1_rel;
   logic [NUM_SIDE-1:0] side_q;

   kbm_pacer #(.TICK_DIV(TICK_DIV)) u_pacer (
      .clk(clk), .rst_n(rst_n), .tick_o(tick));

   kbm_queue #(.DEPTH(QDEPTH), .W(CODE_W)) u_queue (
      .clk(clk), .rst_n(rst_n), .push_i(code_valid_i), .data_i(code_i),
      .pop_i(tick), .head_o(head), .popped_o(popped), .ovf_o(overflow_o));

   kbm_keymap_rom #(.TABLE(KEYMAP)) u_rom (
      .clk(clk), .rd_en_i(popped), .addr_i(head[IDX_W-1:0]), .data_o(map_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld <= 1'b0;
         s1_rel <= 1'b0;
      end else begin
         s1_vld <= popped;
         if (popped) s1_rel <= head[CODE_W-1];
      end
   end

   kbm_matrix #(.NUM_SENSE(NUM_SENSE), .NUM_STROBE(NUM_STROBE), .NUM_SIDE(NUM_SIDE)) u_matrix (
      .clk(clk), .rst_n(rst_n), .apply_i(s1_vld), .map_i(map_q), .release_i(s1_rel),
      .strobe_i(strobe_i), .sense_o(sense_o), .side_o(side_q));

   assign side_o = side_q ^ SIDE_INVERT;

   AST_APPLY_PACED: assert property (@(posedge clk) disable iff (!rst_n)
      s1_vld |=> !s1_vld); // R8
endmodule

// File: tb/tb_kbm_matrix_emu.sv
`timescale 1ns/1ps
module tb_kbm_matrix_emu;
   localparam int DIV = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        code_valid_i = 1'b0;
   logic [7:0]  code_i = '0;
   logic [10:0] strobe_i = '0;
   logic [6:0]  sense_o;
   logic [4:0]  side_o;
   logic        overflow_o;

   kbm_matrix_emu #(.TICK_DIV(DIV)) dut (
      .clk(clk), .rst_n(rst_n), .code_valid_i(code_valid_i), .code_i(code_i),
      .strobe_i(strobe_i), .sense_o(sense_o), .side_o(side_o), .overflow_o(overflow_o));

   always #2.5 clk = ~clk;

   int    n_tests = 0;
   int    n_fail  = 0;
   bit    done    = 0;
   string req     = "R1";

   // reference model state
   byte unsigned m_q[$];
   int  m_cnt = 0;
   bit  m_ovf = 0;
   bit  m_s1_vld = 0;
   byte unsigned m_s1_code = 0;
   int  m_mask[7];
   bit  [4:0] m_side = '0;
   bit  [6:0] m_sense = '0;

   task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_q.delete();
      m_cnt = 0; m_ovf = 0; m_s1_vld = 0; m_side = '0; m_sense = '0;
      for (int r = 0; r < 7; r++) m_mask[r] = 0;
   endtask

   task automatic model_apply(byte unsigned code);
      int idx = code & 8'h7F;
      bit rel = code[7];
      if (idx >= 1 && idx <= 77) begin
         int r = (idx - 1) / 11;
         int c = (idx - 1) % 11;
         if (rel) m_mask[r] &= ~(1 << c);
         else     m_mask[r] |= (1 << c);
      end else if (idx >= 96 && idx <= 100) begin
         m_side[idx - 96] = !rel;
      end
   endtask

   task automatic step();
      @(posedge clk);
      if (!rst_n) model_reset();
      else begin
         int  old_size = m_q.size();
         bit  tick = (m_cnt == DIV - 1);
         bit [6:0] ns;
         for (int r = 0; r < 7; r++) ns[r] = ((m_mask[r] & int'(strobe_i)) != 0);
         if (m_s1_vld) model_apply(m_s1_code);
         if (tick && old_size > 0) begin
            m_s1_vld = 1; m_s1_code = m_q.pop_front();
         end else m_s1_vld = 0;
         if (code_valid_i) begin
            if (old_size < 16) m_q.push_back(code_i);
            else m_ovf = 1;
         end
         m_cnt = tick ? 0 : m_cnt + 1;
         m_sense = ns;
      end
      @(negedge clk);
      chk("sense_o", 16'(sense_o), 16'(m_sense));
      chk("side_o", 16'(side_o), 16'(m_side ^ 5'b10000));
      chk("overflow_o", 16'(overflow_o), 16'(m_ovf));
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic push(byte unsigned c);
      code_i = c; code_valid_i = 1'b1;
      step();
      code_valid_i = 1'b0;
   endtask

   task automatic walk_strobes();
      for (int i = 0; i < 11; i++) begin
         strobe_i = 11'(1 << i);
         step();
      end
      strobe_i = 11'h555; step();
      strobe_i = 11'h2AA; step();
      strobe_i = '0;      step();
      strobe_i = '1;      step();
   endtask

   initial begin
      // R1: reset state
      req = "R1";
      run(2);
      rst_n = 1'b1;
      run(3);
      // R3 press keys across rows/columns; R8 timing checked every cycle
      req = "R3";
      strobe_i = '1;
      push(8'd1); push(8'd12); push(8'd77); push(8'd35); push(8'd23);
      run(6 * DIV);
      // R2 sense follows strobe with one-cycle lag
      req = "R2";
      walk_strobes();
      // R4 release
      req = "R4";
      strobe_i = '1;
      push(8'h80 | 8'd12); push(8'h80 | 8'd77);
      run(3 * DIV);
      walk_strobes();
      // R5 invalid indices ignored, press and release
      req = "R5";
      push(8'd0); push(8'd78); push(8'd95); push(8'd101); push(8'h7F);
      push(8'h80); push(8'h80 | 8'd1 ^ 8'h01);
      run(8 * DIV);
      // R6 / R10 side-band switches
      req = "R6";
      for (int k = 0; k < 5; k++) push(8'(96 + k));
      run(6 * DIV);
      req = "R10";
      walk_strobes();
      req = "R6";
      push(8'h80 | 8'd96); push(8'h80 | 8'd100); push(8'h80 | 8'd98);
      run(4 * DIV);
      // R9 / R7 burst beyond capacity, then drain in order
      req = "R9";
      for (int i = 0; i < 22; i++) push(8'((i % 2) ? (8'h80 | 8'(40 + i / 2)) : 8'(40 + i / 2)));
      run(2);
      req = "R7";
      strobe_i = 11'h3C3;
      run(18 * DIV);
      walk_strobes();
      // R8 one code per tick: a dense burst and sampling each cycle
      req = "R8";
      strobe_i = '1;
      push(8'd60); push(8'h80 | 8'd60); push(8'd61);
      run(4 * DIV);
      // R1 again: reset clears masks, switches and overflow
      req = "R1";
      rst_n = 1'b0;
      run(2);
      rst_n = 1'b1;
      run(4);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog act=running exp=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule